// File: doc/BRIEF.md
# Octal DAC Command Register Bank

This block sits behind a serial slave receiver that has already framed each host write into a 4-bit command, a 4-bit channel address and a data word. It holds eight output channels. Each channel keeps a staging register for new data and a separate output register whose value drives the converter. New data can be staged on several channels and then released together. Each channel also has a power flag: a power-down command clears it, and any command that refreshes the output register sets it again.

A command is presented for one cycle with `cmd_valid_i` high. Its effect is visible on the registered outputs after the next rising clock edge. Command or address codes outside the defined set are dropped without any state change, and `reject_o` pulses for one cycle. The parameter `MID_SCALE_RESET` chooses the reset value of every channel: zero-scale (all zeros), or mid-scale (only the top data bit set).

The decoder's per-cycle action is an enumerated classification with one value for each outcome:
- ACT_NONE: idle.
- ACT_LOAD: stage.
- ACT_REFRESH: copy out.
- ACT_LOAD_REFRESH: stage and copy out one target.
- ACT_LOAD_REFRESH_ALL: stage, then copy out everywhere.
- ACT_SLEEP: power down.
- ACT_REJECT: reserved code.

Every accepted strobe moves from ACT_NONE into exactly one of these for a single cycle and then returns. No action lasts longer than one cycle.

Top module: `dac_cmd_bank`

## Requirements
- R1: Command 0x0 loads `data_i` into the staging register of each addressed channel. `dac_code_o` and `pwr_on_o` do not change.
- R2: Command 0x1 copies the staging register of each addressed channel into its output register and sets that channel's power flag.
- R3: Command 0x2 loads `data_i` into the staging register of each addressed channel. In the same cycle, all eight channels copy their (new) staging value to the output and set their power flags.
- R4: Command 0x3 loads `data_i` into both the staging and output registers of each addressed channel and sets its power flag.
- R5: Command 0x4 clears the power flag of each addressed channel. The output code is kept.
- R6: Address values 0 to 7 select the channel whose code is at `dac_code_o[i*DW +: DW]` and whose flag is at `pwr_on_o[i]`. Address 0xF selects all channels.
- R7: A command in 0x5 to 0xE, or an address in 0x8 to 0xE, changes no state and raises `reject_o` for exactly one cycle. Command 0xF (no operation) changes no state and does not raise `reject_o`.
- R8: A command takes effect at the first rising edge where `cmd_valid_i` is high. While `cmd_valid_i` is low, the command, address and data inputs have no effect and `reject_o` stays low.
- R9: On reset, every output and staging register takes zero, or 2^(DW-1) when `MID_SCALE_RESET` is 1. All power flags are set and `reject_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_i | input | 4 | Command code |
| addr_i | input | 4 | Channel address, 0xF for all channels |
| data_i | input | DW | Data word for load commands |
| dac_code_o | output | NUM_CH*DW | Output register of each channel, channel i at [i*DW +: DW] |
| pwr_on_o | output | NUM_CH | Power flag of each channel |
| reject_o | output | 1 | One-cycle pulse for a dropped reserved command |

## Verification
A corrupted staging register does not show at the ports until an update command copies it to the output. For that reason, every staged write in the bench is followed later by a copy-out command, and all eight codes are compared after each command. A wrong output register or power flag shows on `dac_code_o` or `pwr_on_o` one cycle after the command that caused it. A missing or stretched reject pulse shows on `reject_o` in that same cycle or the next.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    // Command codes; values are decoded from the host frame
    typedef enum logic [3:0] {
        OP_WRITE         = 4'h0,
        OP_UPDATE        = 4'h1,
        OP_WRITE_UPD_ALL = 4'h2,
        OP_WRITE_UPD     = 4'h3,
        OP_PWR_DOWN      = 4'h4,
        OP_NOP           = 4'hF
    } cmd_code_e;

    localparam logic [3:0] ADDR_ALL = 4'hF;

    // One-cycle classification of the presented command
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_LOAD,
        ACT_REFRESH,
        ACT_LOAD_REFRESH,
        ACT_LOAD_REFRESH_ALL,
        ACT_SLEEP,
        ACT_REJECT
    } action_e;

    // Per-channel strobes produced by the decoder
    typedef struct packed {
        logic load_in;
        logic load_dac;
        logic wake;
        logic sleep;
    } slot_ctrl_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_cmd_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     valid_i,
    input  logic [3:0]               cmd_i,
    input  logic [3:0]               addr_i,
    output slot_ctrl_t [NUM_CH-1:0]  ctrl_o,
    output logic                     reject_o
);

    localparam logic [3:0] CH_LIMIT = 4'(NUM_CH);

    action_e             action;
    logic                addr_ok;
    logic [NUM_CH-1:0]   sel;

    assign addr_ok = (addr_i < CH_LIMIT) || (addr_i == ADDR_ALL);

    always_comb begin
        action = ACT_NONE;
        if (valid_i) begin
            if (!addr_ok) begin
                action = ACT_REJECT;
            end else begin
                unique case (cmd_i)
                    OP_WRITE:         action = ACT_LOAD;
                    OP_UPDATE:        action = ACT_REFRESH;
                    OP_WRITE_UPD_ALL: action = ACT_LOAD_REFRESH_ALL;
                    OP_WRITE_UPD:     action = ACT_LOAD_REFRESH;
                    OP_PWR_DOWN:      action = ACT_SLEEP;
                    OP_NOP:           action = ACT_NONE;
                    default:          action = ACT_REJECT;
                endcase
            end
        end
    end

    assign reject_o = (action == ACT_REJECT);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        logic stage_hit;
        logic copy_hit;

        assign sel[g] = (addr_i == ADDR_ALL) || (addr_i == 4'(g));

        assign stage_hit = (action == ACT_LOAD) || (action == ACT_LOAD_REFRESH) ||
                           (action == ACT_LOAD_REFRESH_ALL);
        assign copy_hit  = (action == ACT_REFRESH) || (action == ACT_LOAD_REFRESH);

        assign ctrl_o[g].load_in  = sel[g] && stage_hit;
        assign ctrl_o[g].load_dac = (sel[g] && copy_hit) || (action == ACT_LOAD_REFRESH_ALL);
        assign ctrl_o[g].wake     = ctrl_o[g].load_dac;
        assign ctrl_o[g].sleep    = sel[g] && (action == ACT_SLEEP);
    end

endmodule

// File: rtl/dac_chan_slot.sv
module dac_chan_slot
    import dac_cmd_pkg::*;
#(
    parameter int             DW       = 12,
    parameter logic [DW-1:0]  RST_CODE = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  slot_ctrl_t     ctrl_i,
    input  logic [DW-1:0]  data_i,
    output logic [DW-1:0]  code_o,
    output logic           pwr_o
);

    logic [DW-1:0] stage_q;
    logic [DW-1:0] out_q;
    logic          pwr_q;
    logic [DW-1:0] copy_src;

    // A combined stage-and-copy forwards the fresh word
    assign copy_src = ctrl_i.load_in ? data_i : stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= RST_CODE;
            out_q   <= RST_CODE;
            pwr_q   <= 1'b1;
        end else begin
            if (ctrl_i.load_in)  stage_q <= data_i;
            if (ctrl_i.load_dac) out_q   <= copy_src;
            if (ctrl_i.wake)       pwr_q <= 1'b1;
            else if (ctrl_i.sleep) pwr_q <= 1'b0;
        end
    end

    assign code_o = out_q;
    assign pwr_o  = pwr_q;

endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
    import dac_cmd_pkg::*;
#(
    parameter int DW              = 12,
    parameter int NUM_CH          = 8,
    parameter bit MID_SCALE_RESET = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid_i,
    input  logic [3:0]              cmd_i,
    input  logic [3:0]              addr_i,
    input  logic [DW-1:0]           data_i,
    output logic [NUM_CH*DW-1:0]    dac_code_o,
    output logic [NUM_CH-1:0]       pwr_on_o,
    output logic                    reject_o
);

    localparam logic [DW-1:0] RST_CODE =
        MID_SCALE_RESET ? {1'b1, {(DW-1){1'b0}}} : '0;

    slot_ctrl_t [NUM_CH-1:0] ctrl;
    logic                    reject_d;
    logic                    reject_q;

    dac_cmd_decode #(.NUM_CH(NUM_CH)) u_decode (
        .valid_i  (cmd_valid_i),
        .cmd_i    (cmd_i),
        .addr_i   (addr_i),
        .ctrl_o   (ctrl),
        .reject_o (reject_d)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        dac_chan_slot #(.DW(DW), .RST_CODE(RST_CODE)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (ctrl[g]),
            .data_i (data_i),
            .code_o (dac_code_o[g*DW +: DW]),
            .pwr_o  (pwr_on_o[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= reject_d;
    end

    assign reject_o = reject_q;

endmodule

// File: rtl/dac_cmd_bank_chk.sv
module dac_cmd_bank_chk #(
    parameter int DW     = 12,
    parameter int NUM_CH = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid_i,
    input logic [3:0]            cmd_i,
    input logic [3:0]            addr_i,
    input logic [DW-1:0]         data_i,
    input logic [NUM_CH*DW-1:0]  dac_code_o,
    input logic [NUM_CH-1:0]     pwr_on_o,
    input logic                  reject_o
);

    logic                  rsv_cmd;
    logic                  rsv_addr;
    logic                  rsv;
    logic                  good;
    logic [NUM_CH*DW-1:0]  rep_data;

    assign rsv_cmd  = (cmd_i > 4'h4) && (cmd_i != 4'hF);
    assign rsv_addr = (addr_i >= 4'(NUM_CH)) && (addr_i != 4'hF);
    assign rsv      = cmd_valid_i && (rsv_cmd || rsv_addr);
    assign good     = cmd_valid_i && !rsv_cmd && !rsv_addr;
    assign rep_data = {NUM_CH{data_i}};

    assert_write_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_i == 4'h0) |=> ($stable(dac_code_o) && $stable(pwr_on_o)));

    assert_update_all_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (good && cmd_i == 4'h2) |=> (&pwr_on_o));

    assert_broadcast_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (good && cmd_i == 4'h3 && addr_i == 4'hF) |=> (dac_code_o == $past(rep_data)));

    assert_broadcast_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (good && cmd_i == 4'h4 && addr_i == 4'hF) |=> (pwr_on_o == '0));

    assert_reserved_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |=> reject_o);

    assert_reserved_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsv |=> ($stable(dac_code_o) && $stable(pwr_on_o)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid_i) |=> (!reject_o && $stable(dac_code_o) && $stable(pwr_on_o)));

    assert_reset_powered_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> ((&pwr_on_o) && !reject_o));

endmodule

bind dac_cmd_bank dac_cmd_bank_chk #(.DW(DW), .NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .dac_code_o  (dac_code_o),
    .pwr_on_o    (pwr_on_o),
    .reject_o    (reject_o)
);

// File: tb/dac_cmd_bank_tb.sv
module dac_cmd_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 12;
    localparam int NCH        = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic [3:0]    cmd = 4'h0;
    logic [3:0]    addr = 4'h0;
    logic [DW-1:0] data = '0;

    logic [NCH*DW-1:0] code_z, code_m;
    logic [NCH-1:0]    pwr_z, pwr_m;
    logic              rej_z, rej_m;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DW-1:0]  m_in  [NCH];
    logic [DW-1:0]  m_dac [NCH];
    logic [NCH-1:0] m_pwr;
    logic           m_rej;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_cmd_bank #(.DW(DW), .NUM_CH(NCH), .MID_SCALE_RESET(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(valid), .cmd_i(cmd), .addr_i(addr),
        .data_i(data), .dac_code_o(code_z), .pwr_on_o(pwr_z), .reject_o(rej_z)
    );

    dac_cmd_bank #(.DW(DW), .NUM_CH(NCH), .MID_SCALE_RESET(1'b1)) u_dut_mid (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(valid), .cmd_i(cmd), .addr_i(addr),
        .data_i(data), .dac_code_o(code_m), .pwr_on_o(pwr_m), .reject_o(rej_m)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference behaviour built from the requirements
    task automatic model_apply(input logic [3:0] c, input logic [3:0] a, input logic [DW-1:0] d);
        logic rsv;
        rsv = ((c > 4'h4) && (c != 4'hF)) || ((a > 4'h7) && (a != 4'hF));
        m_rej = rsv;
        if (!rsv) begin
            for (int i = 0; i < NCH; i++) begin
                logic s;
                s = (a == 4'hF) || (a == 4'(i));
                case (c)
                    4'h0: if (s) m_in[i] = d;
                    4'h1: if (s) begin m_dac[i] = m_in[i]; m_pwr[i] = 1'b1; end
                    4'h2: if (s) m_in[i] = d;
                    4'h3: if (s) begin m_in[i] = d; m_dac[i] = d; m_pwr[i] = 1'b1; end
                    4'h4: if (s) m_pwr[i] = 1'b0;
                    default: ;
                endcase
            end
            if (c == 4'h2) begin
                for (int i = 0; i < NCH; i++) begin
                    m_dac[i] = m_in[i];
                    m_pwr[i] = 1'b1;
                end
            end
        end
    endtask

    task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        valid = 1'b1; cmd = c; addr = a; data = d;
        @(negedge clk);
        valid = 1'b0;
        model_apply(c, a, d);
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < NCH; i++)
            check(req, $sformatf("code ch%0d", i), 32'(code_z[i*DW +: DW]), 32'(m_dac[i]));
        check(req, "pwr_on", 32'(pwr_z), 32'(m_pwr));
        check(req, "reject", 32'(rej_z), 32'(m_rej));
    endtask

    task automatic t_reset;
        for (int i = 0; i < NCH; i++) begin
            check("R9", $sformatf("zero reset ch%0d", i), 32'(code_z[i*DW +: DW]), 32'h0);
            check("R9", $sformatf("mid reset ch%0d", i), 32'(code_m[i*DW +: DW]), 32'h800);
        end
        check("R9", "pwr zero variant", 32'(pwr_z), 32'hFF);
        check("R9", "pwr mid variant", 32'(pwr_m), 32'hFF);
        check("R9", "reject", 32'(rej_z), 32'h0);
        // Mid variant staging register must hold mid-scale too
        send(4'h1, 4'h6, 12'h000);
        check("R9", "mid staging copied out", 32'(code_m[6*DW +: DW]), 32'h800);
        compare_all("R2");
    endtask

    task automatic t_write_only;
        send(4'h0, 4'h2, 12'hABC);
        compare_all("R1");
        send(4'h1, 4'h2, 12'h000);
        compare_all("R2");
        check("R2", "ch2 after update", 32'(code_z[2*DW +: DW]), 32'hABC);
    endtask

    task automatic t_power;
        send(4'h4, 4'h5, 12'hFFF);
        compare_all("R5");
        check("R5", "ch5 flag", 32'(pwr_z[5]), 32'h0);
        send(4'h1, 4'h5, 12'h000);
        compare_all("R2");
        check("R2", "ch5 woken", 32'(pwr_z[5]), 32'h1);
    endtask

    task automatic t_write_update;
        send(4'h3, 4'h7, 12'h123);
        compare_all("R4");
        check("R6", "ch7 slice", 32'(code_z[7*DW +: DW]), 32'h123);
        send(4'h3, 4'h0, 12'hFED);
        compare_all("R6");
    endtask

    task automatic t_update_all;
        send(4'h4, 4'hF, 12'h000);
        compare_all("R5");
        check("R5", "all down", 32'(pwr_z), 32'h0);
        send(4'h0, 4'h1, 12'h111);
        send(4'h2, 4'h4, 12'h444);
        compare_all("R3");
        check("R3", "ch1 refreshed", 32'(code_z[1*DW +: DW]), 32'h111);
        send(4'h0, 4'hF, 12'h555);
        compare_all("R6");
        send(4'h1, 4'hF, 12'h000);
        compare_all("R6");
        send(4'h2, 4'hF, 12'h0F0);
        compare_all("R3");
    endtask

    task automatic t_reserved;
        send(4'h4, 4'h3, 12'h000);
        send(4'h5, 4'h0, 12'h321);
        compare_all("R7");
        check("R7", "reject cmd", 32'(rej_z), 32'h1);
        @(negedge clk);
        check("R7", "pulse single cycle", 32'(rej_z), 32'h0);
        send(4'h3, 4'h8, 12'h777);
        compare_all("R7");
        send(4'hE, 4'hF, 12'h777);
        compare_all("R7");
        send(4'hF, 4'h2, 12'h999);
        compare_all("R7");
        check("R7", "nop no reject", 32'(rej_z), 32'h0);
        send(4'h0, 4'hE, 12'h666);
        send(4'h1, 4'hF, 12'h000);
        compare_all("R7");
    endtask

    task automatic t_idle;
        @(negedge clk);
        cmd = 4'h3; addr = 4'hF; data = 12'hBAD; valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_rej = 1'b0;
        compare_all("R8");
        send(4'h3, 4'h4, 12'h4A4);
        compare_all("R8");
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_in[i] = '0;
            m_dac[i] = '0;
        end
        m_pwr = '1;
        m_rej = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_only();
        t_power();
        t_write_update();
        t_update_all();
        t_reserved();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule